// File: doc/BRIEF.md
# Pipelined Multiplier Modulo 2^16+1

This block multiplies two 16-bit operands in the ring of integers modulo 65537, the arithmetic that some block ciphers use for their strongest mixing step. An operand word of all zeros does not mean zero. It stands for 65536, the one residue that cannot be written in 16 bits. Likewise, a true result of 65536 is returned as the all-zero word. Because 65537 is prime, every encoded operand has a multiplicative inverse.

The datapath has three registered stages and never stalls:
- **Capture stage.** Latches the operand pair.
- **Multiply stage.** Forms the full unsigned product and classifies the pair by how many of its operands are zero.
- **Fold stage.** Produces the residue without any divider. It subtracts the upper product half from the lower half and, when that subtraction borrows, adds one.

A new pair may arrive on every clock. Each result leaves with a valid strobe a fixed number of cycles after its pair was presented. The width is a parameter. A width of W gives modulus 2^W+1, so a 4-bit instance works modulo 17 and can be swept completely.

Top module: `zmod_mult_pipe`

## Requirements
- R1: With both operands nonzero, the result equals (a*b) mod (2^W+1). It is computed as lo−hi, or lo−hi+2^W+1 when lo<hi, where lo and hi are the lower and upper W bits of the 2W-bit product.
- R2: With exactly one operand equal to zero (encoding 2^W) and the other equal to x, the result is (2^W+1−x) mod (2^W+1), truncated to W bits.
- R3: With both operands equal to zero, the result is 1.
- R4: A residue of 2^W is output as the all-zero word, whichever operand case produced it (for example, 1×0 or 2×2^(W−1)).
- R5: A pair sampled with in_valid high at rising edge E appears on out_prod with out_valid high after rising edge E+2, so it can be observed three edges after it was captured. out_valid is low in every cycle that carries no result.
- R6: A pair is accepted on every clock edge with in_valid high, with no stall and no gaps. Back-to-back pairs come out back-to-back in the same order.
- R7: A synchronous active-high reset clears every valid flag in the pipeline. Pairs in flight when reset is sampled, and the pair presented at that edge, never produce out_valid.
- R8: A pair presented with in_valid low produces no out_valid, whatever its operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks in_a/in_b as a pair to multiply |
| in_a | input | W | First operand; zero encodes 2^W |
| in_b | input | W | Second operand; zero encodes 2^W |
| out_valid | output | 1 | Marks out_prod as a result |
| out_prod | output | W | Product modulo 2^W+1; zero encodes 2^W |

## Verification
Every result is due on the third rising edge counted from the edge that captures its pair. The bench drives each pair at a falling edge and places the expected value and strobe in a three-deep model queue that advances once per falling edge. At each falling edge it compares the outputs with the oldest entry, so every cycle is checked both for the presence and for the absence of a result. A reset clears the entries in the model queue, mirroring R7. The 4-bit instance is swept over all 256 pairs back to back. The 16-bit instance receives the corner pairs and a long pseudo-random stream with idle gaps.

// File: rtl/zmm_pkg.sv
package zmm_pkg;

  // Operand classification carried from the multiply stage to the fold stage.
  typedef enum logic [1:0] {
    OPK_PLAIN    = 2'd0,  // neither operand is the zero encoding
    OPK_ONE_ZERO = 2'd1,  // exactly one operand encodes 2^W
    OPK_TWO_ZERO = 2'd2   // both operands encode 2^W
  } opkind_e;

endpackage

// File: rtl/zmm_capture.sv
module zmm_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         v_q,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);

  // Only the strobe is reset; operand registers are plain data flops.
  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    a_q <= a_in;
    b_q <= b_in;
  end

endmodule

// File: rtl/zmm_product.sv
module zmm_product
  import zmm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_in,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic           v_q,
  output logic [2*W-1:0] prod_q,
  output opkind_e        kind_q,
  output logic [W-1:0]   other_q
);

  localparam int PW = 2 * W;

  logic           a_zero, b_zero;
  logic [PW-1:0]  prod_d;
  opkind_e        kind_d;

  assign a_zero = (a_in == '0);
  assign b_zero = (b_in == '0);

  // Plain unsigned multiply; the register behind it lets a hard multiplier absorb it.
  assign prod_d = PW'(a_in) * PW'(b_in);

  always_comb begin
    if (a_zero && b_zero)      kind_d = OPK_TWO_ZERO;
    else if (a_zero || b_zero) kind_d = OPK_ONE_ZERO;
    else                       kind_d = OPK_PLAIN;
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    prod_q  <= prod_d;
    kind_q  <= kind_d;
    other_q <= a_in | b_in;   // the nonzero operand when exactly one is zero
  end

  // Every accepted strobe advances one stage per clock, no holding.
  AST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_q == $past(v_in))) else $error("strobe did not advance"); // R6

endmodule

// File: rtl/zmm_fold.sv
module zmm_fold
  import zmm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_in,
  input  logic [2*W-1:0] prod_in,
  input  opkind_e        kind_in,
  input  logic [W-1:0]   other_in,
  output logic           v_q,
  output logic [W-1:0]   res_q
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] lo, hi, diff, folded, res_d;
  logic         borrow;

  assign lo     = prod_in[W-1:0];
  assign hi     = prod_in[2*W-1:W];
  assign borrow = (lo < hi);
  assign diff   = lo - hi;
  // Adding 2^W+1 after a borrow is just +1 once truncated to W bits.
  assign folded = borrow ? (diff + ONE) : diff;

  always_comb begin
    unique case (kind_in)
      OPK_TWO_ZERO: res_d = ONE;              // 2^W * 2^W = 1
      OPK_ONE_ZERO: res_d = ONE - other_in;   // -x, with 2^W wrapping to zero
      default:      res_d = folded;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    res_q <= res_d;
  end

  AST_TWO_ZERO_ONE: assert property (@(posedge clk) disable iff (rst)
    (v_in && kind_in == OPK_TWO_ZERO) |=> (res_q == ONE)) else $error("0*0 not 1"); // R3

endmodule

// File: rtl/zmod_mult_pipe.sv
module zmod_mult_pipe
  import zmm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_prod
);

  localparam int PW = 2 * W;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic           s1_v;
  logic [W-1:0]   s1_a, s1_b;
  logic           s2_v;
  logic [PW-1:0]  s2_prod;
  opkind_e        s2_kind;
  logic [W-1:0]   s2_other;

  zmm_capture #(.W(W)) u_capture (
    .clk  (clk),
    .rst  (rst),
    .v_in (in_valid),
    .a_in (in_a),
    .b_in (in_b),
    .v_q  (s1_v),
    .a_q  (s1_a),
    .b_q  (s1_b)
  );

  zmm_product #(.W(W)) u_product (
    .clk     (clk),
    .rst     (rst),
    .v_in    (s1_v),
    .a_in    (s1_a),
    .b_in    (s1_b),
    .v_q     (s2_v),
    .prod_q  (s2_prod),
    .kind_q  (s2_kind),
    .other_q (s2_other)
  );

  zmm_fold #(.W(W)) u_fold (
    .clk      (clk),
    .rst      (rst),
    .v_in     (s2_v),
    .prod_in  (s2_prod),
    .kind_in  (s2_kind),
    .other_in (s2_other),
    .v_q      (out_valid),
    .res_q    (out_prod)
  );

  // Edges since reset, saturating at 3: gates the history-based checks.
  logic [1:0] since_rst;
  logic       rst_seen;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    rst_seen <= rst;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))) else $error("latency"); // R5

  AST_ONE_ZERO_NEG: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid &&
     (($past(in_a, 3) == '0) != ($past(in_b, 3) == '0)))
    |-> (out_prod == ONE - ($past(in_a, 3) | $past(in_b, 3)))) else $error("one zero"); // R2

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      AST_RESET_CLEARS: assert (!out_valid) else $error("valid after reset"); // R7
    end
  end

endmodule

// File: tb/zmod_mult_pipe_bench.sv
`timescale 1ns/1ps
module zmod_mult_pipe_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic v4 = 1'b0, v16 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic        ov4, ov16;
  logic [3:0]  p4;
  logic [15:0] p16;

  zmod_mult_pipe #(.W(16)) u_zmod_mult_pipe (
    .clk(clk), .rst(rst), .in_valid(v16), .in_a(a16), .in_b(b16),
    .out_valid(ov16), .out_prod(p16));

  zmod_mult_pipe #(.W(4)) u_zmod_mult_pipe_w4 (
    .clk(clk), .rst(rst), .in_valid(v4), .in_a(a4), .in_b(b4),
    .out_valid(ov4), .out_prod(p4));

  int checks = 0;
  int fails  = 0;

  // Three-deep model queues, index 2 is the entry due at this falling edge.
  logic        ev4[3], ev16[3];
  logic [15:0] ed4[3], ed16[3];
  string       vt4[3], vt16[3], dt4[3], dt16[3];

  logic [31:0] rng = 32'h1d87_2b41;

  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic longint ref_mm(longint a, longint b, int w);
    longint m  = longint'(1) << w;
    longint ea = (a == 0) ? m : a;
    longint eb = (b == 0) ? m : b;
    longint r  = (ea * eb) % (m + 1);
    return (r == m) ? 0 : r;
  endfunction

  function automatic string tag_of(longint a, longint b, longint r);
    if (a == 0 && b == 0) return "R3";
    if (a == 0 || b == 0) return (r == 0) ? "R4/R2" : "R2";
    if (r == 0) return "R4/R1";
    return "R1";
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) begin
      ev4[i] = 1'b0; ev16[i] = 1'b0; ed4[i] = '0; ed16[i] = '0;
      vt4[i] = "R7"; vt16[i] = "R7"; dt4[i] = "R1"; dt16[i] = "R1";
    end
  end

  task automatic step(input logic r, input logic iv4, input logic [3:0] ia4, input logic [3:0] ib4,
                      input logic iv16, input logic [15:0] ia16, input logic [15:0] ib16);
    @(negedge clk);
    // W=4 instance
    checks++;
    if (ov4 !== ev4[2]) begin
      fails++;
      $display("FAIL %s W4 out_valid got=%b exp=%b", vt4[2], ov4, ev4[2]);
    end else if (ev4[2]) begin
      checks++;
      if (p4 !== ed4[2][3:0]) begin
        fails++;
        $display("FAIL %s W4 out_prod got=%0d exp=%0d", dt4[2], p4, ed4[2]);
      end
    end
    // W=16 instance
    checks++;
    if (ov16 !== ev16[2]) begin
      fails++;
      $display("FAIL %s W16 out_valid got=%b exp=%b", vt16[2], ov16, ev16[2]);
    end else if (ev16[2]) begin
      checks++;
      if (p16 !== ed16[2]) begin
        fails++;
        $display("FAIL %s W16 out_prod got=%0d exp=%0d", dt16[2], p16, ed16[2]);
      end
    end
    for (int i = 2; i > 0; i--) begin
      ev4[i] = ev4[i-1]; ed4[i] = ed4[i-1]; vt4[i] = vt4[i-1]; dt4[i] = dt4[i-1];
      ev16[i] = ev16[i-1]; ed16[i] = ed16[i-1]; vt16[i] = vt16[i-1]; dt16[i] = dt16[i-1];
    end
    rst = r; v4 = iv4; a4 = ia4; b4 = ib4; v16 = iv16; a16 = ia16; b16 = ib16;
    ev4[0]  = iv4;
    ed4[0]  = 16'(ref_mm(longint'(ia4), longint'(ib4), 4));
    vt4[0]  = iv4 ? "R5/R6" : "R8";
    dt4[0]  = tag_of(longint'(ia4), longint'(ib4), longint'(ed4[0]));
    ev16[0] = iv16;
    ed16[0] = 16'(ref_mm(longint'(ia16), longint'(ib16), 16));
    vt16[0] = iv16 ? "R5/R6" : "R8";
    dt16[0] = tag_of(longint'(ia16), longint'(ib16), longint'(ed16[0]));
    if (r) begin
      // R7: the reset edge drops everything in flight and the pair at that edge.
      for (int i = 0; i < 3; i++) begin
        ev4[i] = 1'b0; ev16[i] = 1'b0; vt4[i] = "R7"; vt16[i] = "R7";
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rng = next_rng(rng);
      step(1'b0, 1'b0, rng[3:0], rng[7:4], 1'b0, rng[15:0], rng[31:16]); // R8
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] ca [12];
    logic [15:0] cb [12];
    ca = '{16'h0000, 16'h0000, 16'h1234, 16'h0001, 16'h0000, 16'h0002,
           16'h8000, 16'hffff, 16'h8000, 16'h0001, 16'hffff, 16'h0000};
    cb = '{16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'hffff, 16'h8000,
           16'h0002, 16'hffff, 16'h8000, 16'h0001, 16'h0000, 16'h0002};

    // Reset state: outputs idle while and after reset is held (R7).
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 4'h3, 4'h5, 1'b1, 16'h1111, 16'h2222);
    idle(3);

    // Exhaustive back-to-back sweep of the W=4 instance (R1..R6).
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        rng = next_rng(rng);
        step(1'b0, 1'b1, 4'(a), 4'(b), 1'b0, rng[15:0], rng[31:16]);
      end
    end
    idle(3);

    // W=16 corners: zero encodings and the 2^16 -> 0 wrap (R2, R3, R4).
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 4'h0, 4'h0, 1'b1, ca[i], cb[i]);

    // W=16 pseudo-random stream with periodic idle pairs (R1, R6, R8).
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] s;
      rng = next_rng(rng);
      s = rng;
      rng = next_rng(rng);
      step(1'b0, rng[0], s[3:0], s[7:4], (i % 7) != 3, s[15:0], s[31:16]);
    end
    idle(3);

    // Reset in mid-stream: in-flight pairs vanish (R7).
    step(1'b0, 1'b1, 4'h7, 4'h9, 1'b1, 16'h0000, 16'h0000);
    step(1'b0, 1'b1, 4'h0, 4'h0, 1'b1, 16'h4321, 16'h0000);
    step(1'b1, 1'b1, 4'h2, 4'h8, 1'b1, 16'h0002, 16'h8000);
    idle(4);
    step(1'b0, 1'b1, 4'h0, 4'h1, 1'b1, 16'h0001, 16'h0000);
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule